// File: doc/BRIEF.md
# Keyed Nonvolatile Write Controller

This block is the register front end of a small nonvolatile word store. Software writes a handful of registers over a simple one-cycle write bus. These are an operation register, a 24-bit target address split over two registers, a key register, and a two-word staging buffer. The staging buffer is filled through a pointer that steps to the next word after each upper-half write. An operation is launched only when the key register has just seen 0x55 and then 0xAA, and the very next register write sets the start bit. The start bit then reads back as 1 for a fixed number of cycles, which models the cell programming time, and clears itself. Software polls it to learn when the store has been updated.

Programming merges the two staged words into an aligned pair of stored words with a bitwise AND, so a cell can only go from 1 to 0. The erase operation sets every stored bit back to 1. The last stored word holds a protection flag in its bit 0. While that bit is 0, the read-back port returns zero for every other word, and the protection word itself stays readable.

Top module: `nvw_ctrl`

## Requirements
- R1: After reset, the operation register reads 0x0000 and every stored word reads back as 0xFFFFFF.
- R2: A write of 1 to bit 15 of the operation register (select 0) starts an operation only if it comes right after writes of 0x55 and then 0xAA to the key register (select 3). Bit 15 then reads 1 from the following cycle onward.
- R3: Bit 15 stays at 1 for exactly PROG_CYCLES clock cycles and then returns to 0 by itself.
- R4: Operation code 0x4001 programs the two staged words into stored words 2k and 2k+1. Here k is taken from address bits [IDX_W:2]. The address is formed from the low register (select 1) and bits 23:16 from the upper register (select 2).
- R5: Programming stores the bitwise AND of the old contents and the staged data, so no stored bit ever goes from 0 to 1 by programming.
- R6: Operation code 0x4003 sets every bit of every stored word to 1.
- R7: A wrong key value, a missing key step, or any other register write between the key writes and the start write cancels the unlock. The start write is then ignored: bit 15 stays 0 and the store is unchanged.
- R8: Select 4 writes the low 16 bits of the staged word chosen by the pointer. Select 5 writes its upper 8 bits and then advances the pointer. Select 6 loads the pointer from data bit 0. The pointer returns to 0 when an operation completes.
- R9: While bit 15 is 1, writes to the address, staging, pointer and operation registers are ignored.
- R10: While bit 0 of the last stored word is 0, reading any other word returns 0x000000, and the last word still returns its stored value.
- R11: After a valid unlock, a start write with an operation code other than 0x4001 or 0x4003 does not start anything.
- R12: A program operation whose address has bits [1:0] non-zero, or any bit above IDX_W set, still runs its full busy time but leaves the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 16 | Register write data |
| ctl_rdata | output | 16 | Operation register: bit 15 busy/start, bits 14:0 operation code |
| rb_index | input | IDX_W | Stored word index to read back |
| rb_data | output | 24 | Read-back data, masked while protection is active |

## Verification
The hardest state to reach is a write to the address or staging registers that arrives in the middle of a running operation. Such a write only matters if it could change the value committed when the operation ends. The bench launches a program and then, during the busy window, rewrites the address, clears a staged word and overwrites the operation register. It then checks that the intended pair got the original data and that the pair the new address would have hit is still blank. Broken unlock sequences, an invalid operation code and misaligned or out-of-range targets are each driven on their own, with store read-back after each one.

// File: rtl/nvw_pkg.sv
// Package: shared constants and types of the keyed nonvolatile write controller.
// Assumes a 24-bit stored word split into a 16-bit low half and an 8-bit high half.
package nvw_pkg;
    localparam int WORD_W = 24;
    localparam int LO_W   = 16;
    localparam int HI_W   = 8;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ADRL = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ADRU = 3'd2;
    localparam logic [SEL_W-1:0] SEL_KEY  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_LATL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_LATH = 3'd5;
    localparam logic [SEL_W-1:0] SEL_PTR  = 3'd6;

    localparam logic [14:0] OP_PROG2 = 15'h4001;
    localparam logic [14:0] OP_ERASE = 15'h4003;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } ul_state_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } word_t;
endpackage

// File: rtl/nvw_unlock.sv
// Module: unlock sequencer. It follows the register write stream and raises
// armed only when the latest two writes were the two key values in order.
// Assumes one write per strobe cycle. Any write during busy drops the state.
module nvw_unlock
    import nvw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       key_data,
    input  logic             busy,
    output logic             armed
);
    ul_state_e state_q;
    ul_state_e state_d;

    // Next-state choice from the current write
    always_comb begin
        state_d = state_q;
        if (we) begin
            if (busy || sel != SEL_KEY) begin
                state_d = UL_IDLE;
            end else if (key_data == KEY_FIRST) begin
                state_d = UL_HALF;
            end else if (key_data == KEY_SECOND && state_q == UL_HALF) begin
                state_d = UL_ARMED;
            end else begin
                state_d = UL_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == UL_ARMED);
endmodule

// File: rtl/nvw_timer.sv
// Module: busy timer. A start pulse raises busy for exactly CYCLES clock
// cycles. done is high in the last busy cycle so the commit lands as busy drops.
// Assumes start is only given while busy is low.
module nvw_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Busy flag and down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/nvw_store.sv
// Module: word store. Programming ANDs two words into an aligned pair, and
// erase sets all bits to 1. Read-back is masked while the protection bit
// (bit 0 of the last word) is 0.
// Assumes prog_go and erase_go are never high together.
module nvw_store
    import nvw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic [IDX_W-2:0]  pair_idx,
    input  word_t             lat0,
    input  word_t             lat1,
    input  logic [IDX_W-1:0]  rb_index,
    output logic [WORD_W-1:0] rb_data,
    output logic              prot_on
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] PROT_IDX = IDX_W'(DEPTH - 1);

    word_t mem_q [DEPTH];

    // Cell array: blank at reset, cleared by program, set by erase
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            localparam logic [IDX_W-2:0] PAIR = (IDX_W-1)'(g / 2);
            always_ff @(posedge clk) begin
                if (!rst_n || erase_go) begin
                    mem_q[g] <= '1;
                end else if (prog_go && pair_idx == PAIR) begin
                    if (g % 2 == 0) mem_q[g] <= mem_q[g] & lat0;
                    else            mem_q[g] <= mem_q[g] & lat1;
                end
            end
        end
    endgenerate

    assign prot_on = ~mem_q[DEPTH-1].lo[0];

    // Read-back with protection mask
    always_comb begin
        if (prot_on && rb_index != PROT_IDX) rb_data = '0;
        else                                  rb_data = mem_q[rb_index];
    end
endmodule

// File: rtl/nvw_ctrl.sv
// Module: top of the keyed nonvolatile write controller. Decodes register
// writes, holds the address, operation and staging registers, and launches
// the timed operation after a valid unlock.
// Assumes a single-cycle write strobe and that read-back is combinational.
module nvw_ctrl
    import nvw_pkg::*;
#(
    parameter int PROG_CYCLES = 8,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        bus_sel,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       ctl_rdata,
    input  logic [IDX_W-1:0]  rb_index,
    output logic [23:0]       rb_data
);
    localparam int ADDR_W = LO_W + HI_W;

    logic [14:0]     op_q;
    logic [LO_W-1:0] adr_lo;
    logic [HI_W-1:0] adr_hi;
    word_t           lat_q [2];
    logic            ptr_q;
    logic            armed;
    logic            busy;
    logic            done;
    logic            start;
    logic            wr_ok;
    logic            op_valid;
    logic            in_range;
    logic            prog_go;
    logic            erase_go;
    logic [ADDR_W-1:0] full_adr;

    assign wr_ok    = bus_we && !busy;
    assign op_valid = (bus_wdata[14:0] == OP_PROG2) || (bus_wdata[14:0] == OP_ERASE);
    assign start    = wr_ok && bus_sel == SEL_CTRL && bus_wdata[15] && armed && op_valid;

    nvw_unlock u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .sel      (bus_sel),
        .key_data (bus_wdata[7:0]),
        .busy     (busy),
        .armed    (armed)
    );

    nvw_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // Operation code register
    always_ff @(posedge clk) begin
        if (!rst_n)                            op_q <= '0;
        else if (wr_ok && bus_sel == SEL_CTRL) op_q <= bus_wdata[14:0];
    end

    // Target address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_lo <= '0;
            adr_hi <= '0;
        end else if (wr_ok && bus_sel == SEL_ADRL) begin
            adr_lo <= bus_wdata;
        end else if (wr_ok && bus_sel == SEL_ADRU) begin
            adr_hi <= bus_wdata[HI_W-1:0];
        end
    end

    // Staging words and their fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q[0] <= '1;
            lat_q[1] <= '1;
            ptr_q    <= 1'b0;
        end else if (done) begin
            ptr_q <= 1'b0;
        end else if (wr_ok) begin
            case (bus_sel)
                SEL_LATL: lat_q[ptr_q].lo <= bus_wdata;
                SEL_LATH: begin
                    lat_q[ptr_q].hi <= bus_wdata[HI_W-1:0];
                    ptr_q           <= ~ptr_q;
                end
                SEL_PTR:  ptr_q <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    assign full_adr = {adr_hi, adr_lo};
    assign in_range = (full_adr[1:0] == 2'b00) && (full_adr[ADDR_W-1:IDX_W+1] == '0);
    assign prog_go  = done && op_q == OP_PROG2 && in_range;
    assign erase_go = done && op_q == OP_ERASE;

    nvw_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .pair_idx (full_adr[IDX_W:2]),
        .lat0     (lat_q[0]),
        .lat1     (lat_q[1]),
        .rb_index (rb_index),
        .rb_data  (rb_data),
        .prot_on  ()
    );

    assign ctl_rdata = {busy, op_q};
endmodule

// File: rtl/nvw_ctrl_chk.sv
// Module: property checker for nvw_ctrl, attached by bind.
// Assumes it sees the top ports plus the unlock, address and commit signals.
module nvw_ctrl_chk
    import nvw_pkg::*;
#(
    parameter int PROG_CYCLES = 8,
    parameter int IDX_W       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [2:0]       bus_sel,
    input logic [15:0]      ctl_rdata,
    input logic [IDX_W-1:0] rb_index,
    input logic [23:0]      rb_data,
    input logic             armed,
    input logic [15:0]      adr_lo,
    input logic             erase_go,
    input logic             prot_on
);
    logic [15:0] run_q;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n)            run_q <= '0;
        else if (ctl_rdata[15]) run_q <= run_q + 1'b1;
        else                   run_q <= '0;
    end

    // R2
    start_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[15]) |-> $past(armed));

    // R11
    start_valid_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[15]) |-> (ctl_rdata[14:0] == OP_PROG2 || ctl_rdata[14:0] == OP_ERASE));

    // R3
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rdata[15]) |-> (run_q == 16'(PROG_CYCLES)));

    // R9
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[15] && bus_we && bus_sel == SEL_ADRL) |=> $stable(adr_lo));

    // R5
    no_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rb_index) && $stable(prot_on) && !$past(erase_go))
            |-> ((rb_data & ~$past(rb_data)) == 24'h0));

    // R10
    protect_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && rb_index != IDX_W'((1 << IDX_W) - 1)) |-> (rb_data == 24'h0));
endmodule

bind nvw_ctrl nvw_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES), .IDX_W(IDX_W)) u_nvw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .ctl_rdata (ctl_rdata),
    .rb_index  (rb_index),
    .rb_data   (rb_data),
    .armed     (armed),
    .adr_lo    (adr_lo),
    .erase_go  (erase_go),
    .prot_on   (~u_store.mem_q[(1 << IDX_W) - 1].lo[0])
);

// File: tb/tb_nvw_ctrl.sv
`timescale 1ns/1ps
// Bench for nvw_ctrl: a vector table of program operations, then directed cases.
module tb_nvw_ctrl;
    localparam int PC    = 8;
    localparam int IW    = 4;
    localparam int DEPTH = 1 << IW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] ctl_rdata;
    logic [IW-1:0] rb_index = '0;
    logic [23:0] rb_data;

    int checks = 0;
    int errors = 0;
    logic [23:0] mdl [DEPTH];

    always #4 clk = ~clk;

    nvw_ctrl #(.PROG_CYCLES(PC), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .ctl_rdata(ctl_rdata),
        .rb_index(rb_index), .rb_data(rb_data)
    );

    // {address low 16, staged word 0, staged word 1}
    localparam logic [63:0] VEC [6] = '{
        {16'h0000, 24'h123456, 24'hABCDEF},
        {16'h0004, 24'hF0F0F0, 24'h0F0F0F},
        {16'h0000, 24'hFF00FF, 24'h00FFFF},
        {16'h0008, 24'h7FFFFF, 24'hFFFFFE},
        {16'h0018, 24'h000000, 24'h800001},
        {16'h0004, 24'hFFFFFF, 24'hFFFFFF}
    };

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic stage(input logic [23:0] w0, input logic [23:0] w1);
        wr(3'd6, 16'h0000);
        wr(3'd4, w0[15:0]); wr(3'd5, {8'h00, w0[23:16]});
        wr(3'd4, w1[15:0]); wr(3'd5, {8'h00, w1[23:16]});
    endtask

    task automatic launch(input logic [15:0] op, output int cyc);
        wr(3'd3, 16'h0055); wr(3'd3, 16'h00AA); wr(3'd0, op | 16'h8000);
        cyc = 0;
        while (ctl_rdata[15] && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic rb(input int i, output logic [23:0] v);
        rb_index = IW'(i);
        #1;
        v = rb_data;
    endtask

    task automatic check_all(input string req);
        logic [23:0] v;
        for (int i = 0; i < DEPTH; i++) begin
            rb(i, v);
            check(req, v, mdl[i]);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [23:0] v;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctl", {8'h0, ctl_rdata}, 24'h0);
        check_all("R1 blank");

        // R4 R5 R8 table of program operations
        for (int n = 0; n < 6; n++) begin
            logic [15:0] a;
            int k;
            a = VEC[n][63:48];
            wr(3'd1, a); wr(3'd2, 16'h0000);
            stage(VEC[n][47:24], VEC[n][23:0]);
            launch(16'h4001, cyc);
            check("R3 busy length", 24'(cyc), 24'(PC));
            k = int'(a[IW:2]) * 2;
            mdl[k]   = mdl[k]   & VEC[n][47:24];
            mdl[k+1] = mdl[k+1] & VEC[n][23:0];
            rb(k, v);   check("R4 R5 even word", v, mdl[k]);
            rb(k+1, v); check("R4 R5 odd word", v, mdl[k+1]);
        end

        // R7 broken unlock sequences
        wr(3'd1, 16'h0010); stage(24'h000000, 24'h000000);
        wr(3'd3, 16'h0055); wr(3'd1, 16'h0010); wr(3'd3, 16'h00AA); wr(3'd0, 16'hC001);
        check("R7 intervening write", {23'h0, ctl_rdata[15]}, 24'h0);
        wr(3'd3, 16'h0055); wr(3'd3, 16'h00AA); wr(3'd2, 16'h0000); wr(3'd0, 16'hC001);
        check("R7 write before start", {23'h0, ctl_rdata[15]}, 24'h0);
        wr(3'd3, 16'h0055); wr(3'd3, 16'h00AB); wr(3'd0, 16'hC001);
        check("R7 wrong key", {23'h0, ctl_rdata[15]}, 24'h0);
        wr(3'd3, 16'h00AA); wr(3'd0, 16'hC001);
        check("R7 missing first key", {23'h0, ctl_rdata[15]}, 24'h0);
        repeat (PC + 2) @(negedge clk);
        check_all("R7 store untouched");

        // R11 invalid operation code
        wr(3'd3, 16'h0055); wr(3'd3, 16'h00AA); wr(3'd0, 16'hC002);
        check("R11 no start", {23'h0, ctl_rdata[15]}, 24'h0);

        // R9 writes during busy ignored
        wr(3'd1, 16'h0014); stage(24'h12F0F0, 24'h345678);
        wr(3'd3, 16'h0055); wr(3'd3, 16'h00AA); wr(3'd0, 16'hC001);
        check("R2 start seen", {23'h0, ctl_rdata[15]}, 24'h1);
        wr(3'd4, 16'h0000); wr(3'd1, 16'h0010); wr(3'd0, 16'h0000);
        cyc = 0;
        while (ctl_rdata[15] && cyc < 1000) begin cyc++; @(negedge clk); end
        check("R9 op write ignored", {8'h0, ctl_rdata}, 24'h004001);
        mdl[10] = 24'h12F0F0; mdl[11] = 24'h345678;
        rb(10, v); check("R9 latch and address held", v, mdl[10]);
        rb(11, v); check("R9 odd word", v, mdl[11]);
        rb(8, v);  check("R9 other pair blank", v, mdl[8]);

        // R8 pointer load selects staged word 1
        wr(3'd1, 16'h0010);
        wr(3'd6, 16'h0001); wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
        launch(16'h4001, cyc);
        mdl[8] = mdl[8] & 24'h12F0F0; mdl[9] = 24'h000000;
        rb(8, v); check("R8 word 0 kept", v, mdl[8]);
        rb(9, v); check("R8 word 1 via pointer", v, mdl[9]);

        // R12 misaligned and out-of-range targets
        stage(24'h000000, 24'h000000);
        wr(3'd1, 16'h0006); launch(16'h4001, cyc);
        check("R12 misaligned busy", 24'(cyc), 24'(PC));
        wr(3'd1, 16'h0000); wr(3'd2, 16'h0001); launch(16'h4001, cyc);
        wr(3'd2, 16'h0000);
        check_all("R12 store untouched");

        // R10 protection bit cleared in last word
        wr(3'd1, 16'h001C); stage(24'h00AAAA, 24'hFFFFFE);
        launch(16'h4001, cyc);
        mdl[14] = mdl[14] & 24'h00AAAA; mdl[15] = mdl[15] & 24'hFFFFFE;
        rb(0, v);  check("R10 masked word", v, 24'h000000);
        rb(14, v); check("R10 masked neighbour", v, 24'h000000);
        rb(15, v); check("R10 protect word readable", v, mdl[15]);

        // R6 erase restores all ones
        launch(16'h4003, cyc);
        check("R6 erase busy", 24'(cyc), 24'(PC));
        for (int i = 0; i < DEPTH; i++) mdl[i] = 24'hFFFFFF;
        check_all("R6 erased");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule